// File: doc/BRIEF.md
# Floating-Point Number Classifier

This combinational block sorts a binary floating-point word into one of ten categories. The word has a sign bit at the top, then an exponent field, then a fraction field. Both field widths are parameters, so the same block serves a single-precision word and very narrow custom formats. The result comes out as a 4-bit category code and as a matching one-hot vector. Three flags come with it: one for NaN and one for finite on the primary operand, and an unordered flag that also takes in a second operand.

A build parameter turns subnormal support off. With it off, every input that would be a subnormal is reported as a zero with the input's sign. A datapath can then route values to special-case handling without decoding the fields itself. Comparison logic can use the unordered flag to skip operand pairs that involve a NaN.

Top module: `fp_classifier`

## Requirements
- R1: An input whose exponent and fraction are both all zeros is reported as zero: code 5 (negative zero) when the sign bit is 1, code 6 (positive zero) when it is 0.
- R2: With subnormal support on, an all-zero exponent with a nonzero fraction gives code 4 (negative subnormal) or code 7 (positive subnormal), chosen by the sign.
- R3: An all-ones exponent with a zero fraction gives code 2 (negative infinity) or code 9 (positive infinity).
- R4: An all-ones exponent with a nonzero fraction is a NaN. It gives code 0 (signalling) when the fraction's top bit is 1 and code 1 (quiet) otherwise, whatever the sign.
- R5: Any other exponent value gives code 3 (negative normal) or code 8 (positive normal).
- R6: With subnormal support off (DENORM_EN = 0), an input with a zero exponent and a nonzero fraction gives code 5 or 6 by its sign, and codes 4 and 7 never appear.
- R7: class_onehot has exactly one bit set, and that bit is at the index equal to class_code.
- R8: is_nan is 1 exactly when the primary operand has code 0 or 1.
- R9: is_finite is 0 exactly when the primary operand is an infinity of either sign (code 2 or 9). A NaN counts as finite.
- R10: unordered is 1 exactly when at least one of the two operands is a NaN of either kind.
- R11: EXP_W and FRAC_W are each at least 3. The block works at the smallest such format, 7 bits wide, as well as at the 32-bit format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 1+EXP_W+FRAC_W | Primary operand: sign, exponent, fraction from MSB down |
| op_b | input | 1+EXP_W+FRAC_W | Second operand, used only for the unordered flag |
| class_code | output | 4 | Category code 0..9 of op_a |
| class_onehot | output | 10 | One-hot form of class_code |
| is_nan | output | 1 | op_a is a NaN of either kind |
| is_finite | output | 1 | op_a is not an infinity |
| unordered | output | 1 | op_a or op_b is a NaN |

## Verification
The bench sweeps every 7-bit word against every 7-bit second operand. A 32-bit instance is driven with the edge encodings of each category. Several kinds of error would show up there. A design that tested the wrong fraction bit would swap signalling and quiet NaNs. One that tested only part of the exponent for all-zeros or all-ones would call the largest normal an infinity, or the smallest normal a subnormal. A design that ignored the sign of a zero or a folded subnormal would report the wrong zero. A design that left out the second operand would miss unordered pairs in which only op_b is a NaN.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  typedef enum logic [3:0] {
    CLS_SNAN     = 4'd0,
    CLS_QNAN     = 4'd1,
    CLS_NEG_INF  = 4'd2,
    CLS_NEG_NORM = 4'd3,
    CLS_NEG_SUB  = 4'd4,
    CLS_NEG_ZERO = 4'd5,
    CLS_POS_ZERO = 4'd6,
    CLS_POS_SUB  = 4'd7,
    CLS_POS_NORM = 4'd8,
    CLS_POS_INF  = 4'd9
  } fpc_class_e;

  localparam int unsigned NUM_CLASSES = 10;

  // Per-operand field summary produced by the field splitter.
  typedef struct packed {
    logic sign;
    logic exp_zero;
    logic exp_ones;
    logic frac_zero;
    logic frac_top;
  } fpc_fields_t;

  // Map the field summary to a category. sub_en selects subnormal support.
  function automatic fpc_class_e fpc_classify(input fpc_fields_t f, input logic sub_en);
    fpc_class_e c;
    if (f.exp_ones) begin
      if (f.frac_zero) c = f.sign ? CLS_NEG_INF : CLS_POS_INF;
      else             c = f.frac_top ? CLS_SNAN : CLS_QNAN;
    end else if (f.exp_zero) begin
      if (f.frac_zero || !sub_en) c = f.sign ? CLS_NEG_ZERO : CLS_POS_ZERO;
      else                        c = f.sign ? CLS_NEG_SUB  : CLS_POS_SUB;
    end else begin
      c = f.sign ? CLS_NEG_NORM : CLS_POS_NORM;
    end
    return c;
  endfunction

endpackage

// File: rtl/fpc_field_split.sv
module fpc_field_split
  import fpc_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word,
  output fpc_fields_t           fields,
  output logic                  nan_hit,
  output logic                  inf_hit
);
  localparam int unsigned SIGN_POS = EXP_W + FRAC_W;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f  = word[SIGN_POS-1:FRAC_W];
  assign frac_f = word[FRAC_W-1:0];

  always_comb begin
    fields.sign      = word[SIGN_POS];
    fields.exp_zero  = (exp_f == '0);
    fields.exp_ones  = &exp_f;
    fields.frac_zero = (frac_f == '0);
    fields.frac_top  = frac_f[FRAC_W-1];
  end

  assign nan_hit = fields.exp_ones & ~fields.frac_zero;
  assign inf_hit = fields.exp_ones &  fields.frac_zero;

endmodule

// File: rtl/fpc_class_encode.sv
module fpc_class_encode
  import fpc_pkg::*;
#(
  parameter bit DENORM_EN = 1'b1
) (
  input  fpc_fields_t fields,
  output logic [3:0]  code
);
  fpc_class_e cls;

  always_comb begin
    cls  = fpc_classify(fields, DENORM_EN);
    code = cls;
  end

  // Subnormal folding: categories 4 and 7 must not appear when disabled.
  always_comb begin
    if (!DENORM_EN) begin
      assert_no_subnormal_R6: assert (code != 4'd4 && code != 4'd7)
        else $error("subnormal category produced with support disabled");
    end
  end

endmodule

// File: rtl/fpc_onehot.sv
module fpc_onehot #(
  parameter int unsigned N = 10
) (
  input  logic [3:0]   code,
  output logic [N-1:0] onehot
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign onehot[i] = (code == 4'(i));
  end
endmodule

// File: rtl/fp_classifier.sv
module fp_classifier
  import fpc_pkg::*;
#(
  parameter int unsigned EXP_W     = 8,
  parameter int unsigned FRAC_W    = 23,
  parameter bit          DENORM_EN = 1'b1
) (
  input  logic [EXP_W+FRAC_W:0] op_a,
  input  logic [EXP_W+FRAC_W:0] op_b,
  output logic [3:0]            class_code,
  output logic [9:0]            class_onehot,
  output logic                  is_nan,
  output logic                  is_finite,
  output logic                  unordered
);
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W;
  localparam int unsigned NUM_OP = 2;

  logic [NUM_OP-1:0][WORD_W-1:0] ops;
  fpc_fields_t                   flds [NUM_OP];
  logic [NUM_OP-1:0]             nan_v;
  logic [NUM_OP-1:0]             inf_v;

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar g = 0; g < NUM_OP; g++) begin : g_split
    fpc_field_split #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_split (
      .word    (ops[g]),
      .fields  (flds[g]),
      .nan_hit (nan_v[g]),
      .inf_hit (inf_v[g])
    );
  end

  fpc_class_encode #(.DENORM_EN(DENORM_EN)) u_enc (
    .fields (flds[0]),
    .code   (class_code)
  );

  fpc_onehot #(.N(NUM_CLASSES)) u_oh (
    .code   (class_code),
    .onehot (class_onehot)
  );

  assign is_nan    = nan_v[0];
  assign is_finite = ~inf_v[0];
  assign unordered = |nan_v;

  // Cross-checks between the splitter flags and the encoder output.
  always_comb begin
    assert_onehot_R7: assert ($onehot(class_onehot) && class_onehot[class_code])
      else $error("one-hot vector disagrees with code");
    assert_nan_R8: assert (is_nan == (class_code <= 4'd1))
      else $error("nan flag disagrees with code");
    assert_finite_R9: assert (is_finite == !(class_code == 4'd2 || class_code == 4'd9))
      else $error("finite flag disagrees with code");
    if (is_nan) begin
      assert_unordered_R10: assert (unordered)
        else $error("unordered clear while primary operand is NaN");
    end
  end

endmodule

// File: tb/fp_classifier_test.sv
module fp_classifier_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [6:0]  a7, b7;
  logic [31:0] a32, b32;

  logic [3:0] c7, cz, c32;
  logic [9:0] oh7, ohz, oh32;
  logic nan7, fin7, uno7, nanz, finz, unoz, nan32, fin32, uno32;

  fp_classifier #(.EXP_W(8), .FRAC_W(23), .DENORM_EN(1'b1)) uut (
    .op_a(a32), .op_b(b32), .class_code(c32), .class_onehot(oh32),
    .is_nan(nan32), .is_finite(fin32), .unordered(uno32));
  fp_classifier #(.EXP_W(3), .FRAC_W(3), .DENORM_EN(1'b1)) uut7 (
    .op_a(a7), .op_b(b7), .class_code(c7), .class_onehot(oh7),
    .is_nan(nan7), .is_finite(fin7), .unordered(uno7));
  fp_classifier #(.EXP_W(3), .FRAC_W(3), .DENORM_EN(1'b0)) uutz (
    .op_a(a7), .op_b(b7), .class_code(cz), .class_onehot(ohz),
    .is_nan(nanz), .is_finite(finz), .unordered(unoz));

  task automatic chk(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d (a7=%b b7=%b a32=%h)", req, act, exp_v, a7, b7, a32);
    end
  endtask

  // Expected category for a 7-bit word, computed from field values.
  function automatic int ref7(input int x, input bit sub_en);
    int s, e, f;
    s = x / 64;
    e = (x / 8) % 8;
    f = x % 8;
    if (e == 7) return (f == 0) ? (s ? 2 : 9) : (f >= 4 ? 0 : 1);
    if (e == 0) begin
      if (f == 0 || !sub_en) return s ? 5 : 6;
      return s ? 4 : 7;
    end
    return s ? 3 : 8;
  endfunction

  function automatic string tag_of(input int c, input bit folded);
    if (folded) return "R6";
    case (c)
      0, 1:    return "R4";
      2, 9:    return "R3";
      4, 7:    return "R2";
      5, 6:    return "R1";
      default: return "R5";
    endcase
  endfunction

  task automatic check32(input logic [31:0] v, input int exp_c);
    @(posedge clk);
    a32 = v;
    b32 = 32'h3F80_0000;
    @(negedge clk);
    chk({tag_of(exp_c, 1'b0), "_R11 code32"}, int'(c32), exp_c);
    chk("R7 onehot32", int'(oh32), 1 << exp_c);
    chk("R8 nan32", int'(nan32), (exp_c <= 1) ? 1 : 0);
    chk("R9 finite32", int'(fin32), (exp_c == 2 || exp_c == 9) ? 0 : 1);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    a7 = '0; b7 = '0; a32 = '0; b32 = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 initial zero code", int'(c32), 6);
    chk("R10 initial unordered", int'(uno32), 0);

    // Edge encodings at 32 bits (R11).
    check32(32'h0000_0000, 6);
    check32(32'h8000_0000, 5);
    check32(32'h0000_0001, 7);
    check32(32'h007F_FFFF, 7);
    check32(32'h8000_0001, 4);
    check32(32'h807F_FFFF, 4);
    check32(32'h0080_0000, 8);
    check32(32'h7F7F_FFFF, 8);
    check32(32'h8080_0000, 3);
    check32(32'hFF7F_FFFF, 3);
    check32(32'h7F80_0000, 9);
    check32(32'hFF80_0000, 2);
    check32(32'h7FC0_0000, 0);
    check32(32'hFFFF_FFFF, 0);
    check32(32'h7F80_0001, 1);
    check32(32'hFFBF_FFFF, 1);

    // Unordered with NaN only on the second operand (R10).
    @(posedge clk);
    a32 = 32'h3F80_0000;
    b32 = 32'h7F80_0001;
    @(negedge clk);
    chk("R10 nan on op_b only", int'(uno32), 1);
    chk("R8 op_b nan does not set is_nan", int'(nan32), 0);

    // Exhaustive 7-bit sweep over both operands (R1-style tags per class).
    for (int i = 0; i < 128; i++) begin
      for (int j = 0; j < 128; j++) begin
        int ea, ez, eb;
        @(posedge clk);
        a7 = 7'(i);
        b7 = 7'(j);
        @(negedge clk);
        ea = ref7(i, 1'b1);
        ez = ref7(i, 1'b0);
        eb = ref7(j, 1'b1);
        if (j == 0 || j == 127) begin
          chk({tag_of(ea, 1'b0), "_R11 code7"}, int'(c7), ea);
          chk({tag_of(ez, ez != ea), " code7 folded"}, int'(cz), ez);
          chk("R7 onehot7", int'(oh7), 1 << ea);
          chk("R7 onehot7 folded", int'(ohz), 1 << ez);
          chk("R8 nan7", int'(nan7), (ea <= 1) ? 1 : 0);
          chk("R9 finite7", int'(fin7), (ea == 2 || ea == 9) ? 0 : 1);
          chk("R9 finite7 folded", int'(finz), (ez == 2 || ez == 9) ? 0 : 1);
        end
        chk("R10 unordered7", int'(uno7), (ea <= 1 || eb <= 1) ? 1 : 0);
        chk("R10 unordered7 folded", int'(unoz), (ea <= 1 || eb <= 1) ? 1 : 0);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule